// File: doc/BRIEF.md
# Two-Phase Binary Spike Encoder

This block turns a strictly binary picture into input-layer spike events for a spiking classifier. A caller presents the whole picture as a flat bit vector, with one bit for each pixel, and pulses a start line. The encoder takes a private copy of the picture and the gap setting in that same cycle. It then runs a fixed sequence. First, one cycle fires every neuron whose pixel is dark. Next comes a programmable number of quiet cycles. Then one cycle fires every neuron whose pixel is light. Last, a single completion pulse tells the caller that the next picture may be presented.

A pixel's value is carried only by which of the two shared instants it spikes in. All dark pixels spike together and all light pixels spike together. The two phase strobes are also brought out so that downstream timing logic can measure the interval from each group to an output spike. A training pass applies one picture after another. Each picture waits for the previous completion pulse.

Top module: `spike_phase_encoder`

## Requirements
- R1: While reset is held and after it is released, with no start, `dark_fire_o`, `light_fire_o`, `frame_done_o` and `spikes_o` are all zero.
- R2: A start seen at a clock edge while idle makes `dark_fire_o` high for exactly the next cycle. In that cycle `spikes_o` equals the pixel vector captured at the start edge, where a 1 bit means a dark pixel.
- R3: `light_fire_o` is high for exactly one cycle, G cycles after the `dark_fire_o` cycle. In that cycle `spikes_o` is the bitwise inverse of the captured vector.
- R4: G is the value of `gap_cycles_i` captured at the start edge. A value of 0 selects the default of 16 cycles.
- R5: `frame_done_o` is high for exactly the one cycle that follows the `light_fire_o` cycle. The encoder is idle again after that cycle.
- R6: A start that arrives in any cycle from the start edge through the completion cycle is ignored. It causes no second strobe and no change to the running sequence.
- R7: Outside the two phase cycles, `spikes_o` is all zero.
- R8: An all-dark picture still produces the `light_fire_o` cycle, with an empty spike vector. An all-light picture still produces the `dark_fire_o` cycle, with an empty vector.
- R9: Changes on `pixels_i` or `gap_cycles_i` after the start edge have no effect on the running sequence.
- R10: At most one of `dark_fire_o`, `light_fire_o` and `frame_done_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start strobe; only accepted while idle |
| pixels_i | input | SIDE*SIDE | Picture bitmap, 1 = dark |
| gap_cycles_i | input | GAP_W | Cycles from the dark phase to the light phase; 0 selects 16 |
| spikes_o | output | SIDE*SIDE | Spike vector, non-zero only in a phase cycle |
| dark_fire_o | output | 1 | Dark-phase strobe |
| light_fire_o | output | 1 | Light-phase strobe |
| frame_done_o | output | 1 | One-cycle completion pulse |

## Verification
Call the edge that samples start the start edge, and count cycles from the first cycle after it as cycle 1. The dark strobe and its spikes are due in cycle 1. The light strobe is due in cycle 1+G and the completion pulse in cycle 2+G. All three come straight from state registers, so none of them needs a further register stage. Each scenario task drives its inputs at the falling edge and then walks forward one falling edge at a time through cycle 3+G. At every step it compares all four outputs with the values those cycle numbers predict. Disturbing starts and input changes are applied during the run, and the walk checks that the schedule stays the same.

// File: rtl/spe_pkg.sv
package spe_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DARK  = 3'd1,
    PH_WAIT  = 3'd2,
    PH_LIGHT = 3'd3,
    PH_DONE  = 3'd4
  } phase_t;
endpackage

// File: rtl/spe_gap_timer.sv
module spe_gap_timer #(
  parameter int GAP_W       = 8,
  parameter int GAP_DEFAULT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             tick_i,
  output logic             last_o
);
  localparam logic [GAP_W-1:0] DEF_GAP = GAP_W'(GAP_DEFAULT);

  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | tick_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = (gap_i == '0) ? DEF_GAP : gap_i;
    else if (tick_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == GAP_W'(1));

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |-> (cnt_q != '0));
endmodule

// File: rtl/spe_phase_ctrl.sv
module spe_phase_ctrl
  import spe_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   last_i,
  output logic   load_o,
  output logic   tick_o,
  output phase_t phase_o
);
  phase_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE:          if (start_i) ph_d = PH_DARK;
      PH_DARK, PH_WAIT: ph_d = last_i ? PH_LIGHT : PH_WAIT;
      PH_LIGHT:         ph_d = PH_DONE;
      PH_DONE:          ph_d = PH_IDLE;
      default:          ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign load_o  = (ph_q == PH_IDLE) & start_i;
  assign tick_o  = (ph_q == PH_DARK) | (ph_q == PH_WAIT);
  assign phase_o = ph_q;

  // R5
  done_after_light_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_LIGHT) |=> (ph_q == PH_DONE));
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DONE) |=> (ph_q == PH_IDLE));
  // R6
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && start_i) |=> (ph_q != PH_DARK));
  // R2
  idle_start_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && start_i) |=> (ph_q == PH_DARK));
endmodule

// File: rtl/spe_spike_drive.sv
module spe_spike_drive #(
  parameter int NPIX = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_i,
  input  logic [NPIX-1:0] pix_i,
  input  logic            dark_i,
  input  logic            light_i,
  output logic [NPIX-1:0] spikes_o
);
  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    logic img_q, img_d;

    assign img_d = cap_i ? pix_i[p] : img_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     img_q <= 1'b0;
      else if (cap_i) img_q <= img_d;
    end

    assign spikes_o[p] = (dark_i & img_q) | (light_i & ~img_q);
  end
endmodule

// File: rtl/spike_phase_encoder.sv
module spike_phase_encoder
  import spe_pkg::*;
#(
  parameter int SIDE        = 3,
  parameter int GAP_W       = 8,
  parameter int GAP_DEFAULT = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [SIDE*SIDE-1:0]   pixels_i,
  input  logic [GAP_W-1:0]       gap_cycles_i,
  output logic [SIDE*SIDE-1:0]   spikes_o,
  output logic                   dark_fire_o,
  output logic                   light_fire_o,
  output logic                   frame_done_o
);
  localparam int NPIX = SIDE * SIDE;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic   load, tick, last;
  phase_t phase;

  spe_phase_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .last_i  (last),
    .load_o  (load),
    .tick_o  (tick),
    .phase_o (phase)
  );

  spe_gap_timer #(.GAP_W(GAP_W), .GAP_DEFAULT(GAP_DEFAULT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (load),
    .gap_i  (gap_cycles_i),
    .tick_i (tick),
    .last_o (last)
  );

  assign dark_fire_o  = (phase == PH_DARK);
  assign light_fire_o = (phase == PH_LIGHT);
  assign frame_done_o = (phase == PH_DONE);

  spe_spike_drive #(.NPIX(NPIX)) u_drive (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cap_i    (load),
    .pix_i    (pixels_i),
    .dark_i   (dark_fire_o),
    .light_i  (light_fire_o),
    .spikes_o (spikes_o)
  );

  // R10
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({dark_fire_o, light_fire_o, frame_done_o}));
  // R7
  quiet_spikes_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(dark_fire_o || light_fire_o) |-> (spikes_o == '0));
  // R2
  dark_image_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    dark_fire_o |-> (spikes_o == $past(pixels_i)));
  // R5
  light_then_done_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    light_fire_o |=> frame_done_o);
endmodule

// File: tb/spike_phase_encoder_tb.sv
module spike_phase_encoder_tb;
  localparam int SIDE = 3;
  localparam int NPIX = SIDE * SIDE;
  localparam int GAP_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [NPIX-1:0]  pixels_i = '0;
  logic [GAP_W-1:0] gap_cycles_i = '0;
  logic [NPIX-1:0]  spikes_o;
  logic             dark_fire_o, light_fire_o, frame_done_o;

  int n_checks = 0;
  int n_errs   = 0;

  always #5 clk = ~clk;

  spike_phase_encoder #(.SIDE(SIDE), .GAP_W(GAP_W), .GAP_DEFAULT(16)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .pixels_i     (pixels_i),
    .gap_cycles_i (gap_cycles_i),
    .spikes_o     (spikes_o),
    .dark_fire_o  (dark_fire_o),
    .light_fire_o (light_fire_o),
    .frame_done_o (frame_done_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_outputs(input string req);
    check({req, " dark"},   32'(dark_fire_o),  32'd0);
    check({req, " light"},  32'(light_fire_o), 32'd0);
    check({req, " done"},   32'(frame_done_o), 32'd0);
    check({req, " spikes"}, 32'(spikes_o),     32'd0);
  endtask

  // Walks one picture through the full schedule; disturb exercises R6 and R9.
  task automatic run_frame(input logic [NPIX-1:0] pix, input logic [GAP_W-1:0] gap,
                           input bit disturb, input string tag);
    int g;
    g = (gap == 0) ? 16 : int'(gap);
    @(negedge clk);
    start_i = 1'b1; pixels_i = pix; gap_cycles_i = gap;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin pixels_i = ~pix; gap_cycles_i = 8'd3; end
    for (int t = 1; t <= g + 3; t++) begin
      logic [NPIX-1:0] exp_sp;
      exp_sp = (t == 1) ? pix : ((t == g + 1) ? ~pix : '0);
      check({tag, " R2 dark strobe"},  32'(dark_fire_o),  32'(t == 1));
      check({tag, " R3 light strobe"}, 32'(light_fire_o), 32'(t == g + 1));
      check({tag, " R5 done pulse"},   32'(frame_done_o), 32'(t == g + 2));
      check({tag, " R7 spikes"},       32'(spikes_o),     32'(exp_sp));
      start_i = disturb && (t == 2 || t == g + 2);
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_outputs("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_outputs("R1 after reset");

    run_frame(9'b101_010_110, 8'd5, 1'b0, "basic");
    run_frame(9'b011_100_001, 8'd1, 1'b0, "gap1");
    run_frame(9'b110_011_010, 8'd0, 1'b0, "R4 default gap");
    run_frame(9'b111_111_111, 8'd2, 1'b0, "R8 all dark");
    run_frame(9'b000_000_000, 8'd3, 1'b0, "R8 all light");
    run_frame(9'b100_100_111, 8'd6, 1'b1, "R6 R9 disturb");
    run_frame(9'b010_101_010, 8'd4, 1'b0, "back to back");
    idle_outputs("R1 idle end");

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule